// File: doc/BRIEF.md
# Shared Local-RAM Bridge Arbiter

This block lets a master on an external system bus read and write the local RAM of a CPU board. Each external cycle is marked by an active-low strobe. The strobe is asynchronous to the board clock. The upper address bits of the cycle are compared with a base value taken from configuration inputs, which stand in for board jumpers. When they match, a registered hit raises an active-low bus request to the CPU. The block then waits for the CPU's active-low bus acknowledge. Only after that acknowledge does it hand the RAM to the external master. While the CPU has given up its bus, the output enable of the CPU address latch is held off.

A single arbiter shares the RAM among three requesters: refresh, the granted external access and the CPU. CPU and refresh grants last a fixed number of cycles. An external grant lasts as long as the strobe is held. The external acknowledge asserts once data is valid. The two buses order their bytes in opposite ways, so the block steers the byte lanes to match. It also forwards the local word address to the RAM. Either reset input (power-on or external init) returns everything to idle.

Request machine states: RQ_IDLE, RQ_WAIT, RQ_OWN, RQ_DONE.
- RQ_IDLE→RQ_WAIT on a registered hit.
- RQ_WAIT→RQ_OWN when the acknowledge is seen.
- RQ_WAIT→RQ_DONE if the strobe is dropped first.
- RQ_OWN→RQ_DONE when the strobe is released.
- RQ_DONE→RQ_IDLE when the acknowledge deasserts.

Arbiter states: ARB_IDLE, ARB_CPU, ARB_REF, ARB_EXT.
- ARB_IDLE goes to ARB_REF, ARB_EXT or ARB_CPU by priority.
- ARB_CPU and ARB_REF return to ARB_IDLE after CYC_LEN cycles.
- ARB_EXT returns to ARB_IDLE when the synchronized strobe ends.

Top module: `shmem_bridge`

## Requirements
- R1: A strobe whose address bits [ADDR_W-1 -: BASE_W] differ from `base_sel` never asserts `busrq_n`.
- R2: For a matching strobe, `busrq_n` goes low on the fourth rising edge after the strobe falls. The path is two synchronizer flops, one hit flop and one state flop.
- R3: `gnt_ext` rises on the second rising edge after `busak_n` goes low, and is never high while `busak_n` is high.
- R4: `latch_oe_n` is high whenever `busak_n` is low, and low while the CPU keeps its bus.
- R5: `sys_xack_n` goes low CYC_LEN-1 edges after `gnt_ext` rises. It stays low until the strobe is released, and is low only during `gnt_ext`.
- R6: `busrq_n` stays low until the transfer ends. It rises on the third edge after the strobe rises, on the same edge that `sys_xack_n` rises.
- R7: A pending CPU request is granted on the second edge after `busak_n` deasserts: one clock in RQ_IDLE, then the grant.
- R8: When requests meet in ARB_IDLE, refresh wins over the external access, and the external access wins over the CPU.
- R9: Refresh is not granted twice in a row while another requester is waiting.
- R10: At most one grant is high at a time, and each CPU or refresh grant lasts exactly CYC_LEN cycles.
- R11: Lane steering during an external grant works as follows. `lane_en` bits are {high, swap, direct}.
  - Odd byte (`sys_addr[0]`=1, `sys_word`=0): only `direct` is on, RAM[7:0]↔sys[7:0], `ram_be`=01.
  - Even byte: only `swap` is on, RAM[15:8]↔sys[7:0], `ram_be`=10.
  - Word: `direct` and `high` are on, lanes pass straight, `ram_be`=11.
  - Undriven data bits read 0.
  - Outside a grant, `lane_en`, `ram_be`, `ram_wdata`, `sys_rdata` and `ram_addr` are 0.
- R12: Low on either `por_n` or `init_n` forces idle at once. `busrq_n` is high, all grants and lane enables are off, and `sys_xack_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| por_n | input | 1 | Power-on reset, active low |
| init_n | input | 1 | External init reset, active low |
| base_sel | input | BASE_W | Configured base for the upper address bits |
| sys_addr | input | ADDR_W | External bus address |
| sys_strobe_n | input | 1 | External cycle strobe, asynchronous, active low |
| sys_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| sys_wdata | input | 16 | External write data |
| sys_rdata | output | 16 | Steered read data to external bus |
| sys_xack_n | output | 1 | External acknowledge, data valid, active low |
| busrq_n | output | 1 | Bus request to CPU, active low |
| busak_n | input | 1 | Bus acknowledge from CPU, active low |
| latch_oe_n | output | 1 | CPU address latch output enable, active low |
| cpu_req | input | 1 | CPU RAM cycle request |
| gnt_cpu | output | 1 | RAM granted to CPU |
| ref_req | input | 1 | Refresh request |
| gnt_ref | output | 1 | RAM granted to refresh |
| gnt_ext | output | 1 | RAM granted to external master |
| lane_en | output | 3 | Lane path enables {high, swap, direct} |
| ram_be | output | 2 | RAM byte enables {[15:8], [7:0]} |
| ram_addr | output | ADDR_W-BASE_W-1 | Local RAM word address |
| ram_wdata | output | 16 | Steered write data to RAM |
| ram_rdata | input | 16 | RAM read data |

## Verification
Each result falls due a fixed number of rising edges after its stimulus:

| Result | Due after |
|---|---|
| `busrq_n` low | 4 edges after the strobe falls |
| `gnt_ext` and the lane outputs | 2 edges after the acknowledge |
| `sys_xack_n` low | CYC_LEN-1 edges after the grant |
| `busrq_n` and `sys_xack_n` release | 3 edges after the strobe rises |
| CPU grant | 2 edges after the acknowledge drops |
| CPU or refresh grant | CYC_LEN cycles, then one idle cycle |

The bench drives and samples 2 ns after a rising edge, and counts edges explicitly. It checks a result both one edge before it is due and at the edge it is due, so early and late changes are both caught. Randomized transfers mix byte and word widths, odd and even addresses, and data patterns. Their steering is compared against bench functions.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

    typedef enum logic [1:0] {
        RQ_IDLE,
        RQ_WAIT,
        RQ_OWN,
        RQ_DONE
    } rq_state_e;

    typedef enum logic [1:0] {
        ARB_IDLE,
        ARB_CPU,
        ARB_REF,
        ARB_EXT
    } arb_state_e;

    localparam int unsigned LANE_W = 8;
    localparam int unsigned DATA_W = 2 * LANE_W;

    // lane path indices inside lane_en
    localparam int unsigned LP_DIRECT = 0;
    localparam int unsigned LP_SWAP   = 1;
    localparam int unsigned LP_HIGH   = 2;

endpackage

// File: rtl/shm_addr_match.sv
module shm_addr_match #(
    parameter int unsigned BASE_W = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] addr_top,
    input  logic [BASE_W-1:0] base_sel,
    input  logic              strobe_n,
    output logic              strobe_act,
    output logic              hit_q
);

    logic [SYNC_STAGES-1:0] sync_q;

    generate
        for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[gi] <= 1'b1;
                    else        sync_q[gi] <= strobe_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[gi] <= 1'b1;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    assign strobe_act = ~sync_q[SYNC_STAGES-1];

    // registered compare result feeding the request machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= strobe_act && (addr_top == base_sel);
    end

endmodule

// File: rtl/shm_req_fsm.sv
module shm_req_fsm
    import shmem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_q,
    input  logic strobe_act,
    input  logic busak_n,
    output logic busrq_n,
    output logic ext_want,
    output logic rq_idle
);

    rq_state_e st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RQ_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            RQ_IDLE: if (hit_q) st_nxt = RQ_WAIT;
            RQ_WAIT: begin
                if (!strobe_act)   st_nxt = RQ_DONE;
                else if (!busak_n) st_nxt = RQ_OWN;
            end
            RQ_OWN:  if (!strobe_act) st_nxt = RQ_DONE;
            RQ_DONE: if (busak_n) st_nxt = RQ_IDLE;
            default: st_nxt = RQ_IDLE;
        endcase
    end

    always_comb begin
        busrq_n  = 1'b1;
        ext_want = 1'b0;
        rq_idle  = 1'b0;
        unique case (st)
            RQ_IDLE: rq_idle = 1'b1;
            RQ_WAIT: busrq_n = 1'b0;
            RQ_OWN: begin
                busrq_n  = 1'b0;
                ext_want = strobe_act;
            end
            RQ_DONE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/shm_arb_fsm.sv
module shm_arb_fsm
    import shmem_pkg::*;
#(
    parameter int unsigned CYC_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_ok,
    input  logic ref_req,
    input  logic ext_want,
    input  logic strobe_act,
    output logic gnt_cpu,
    output logic gnt_ref,
    output logic gnt_ext,
    output logic data_valid
);

    localparam int unsigned CNT_W = $clog2(CYC_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_LEN - 1);

    arb_state_e st, st_nxt;
    logic [CNT_W-1:0] cnt;
    logic ref_last;
    logic ref_wins;

    // refresh yields once after its own grant when someone else waits
    assign ref_wins = ref_req && !(ref_last && (ext_want || cpu_ok));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ARB_IDLE;
            cnt      <= '0;
            ref_last <= 1'b0;
        end else begin
            st <= st_nxt;
            if (st_nxt == ARB_IDLE || st == ARB_IDLE) cnt <= '0;
            else if (cnt != LAST)                     cnt <= cnt + 1'b1;
            if (st == ARB_REF)
                ref_last <= 1'b1;
            else if (st == ARB_IDLE && (st_nxt == ARB_EXT || st_nxt == ARB_CPU))
                ref_last <= 1'b0;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ARB_IDLE: begin
                if (ref_wins)      st_nxt = ARB_REF;
                else if (ext_want) st_nxt = ARB_EXT;
                else if (cpu_ok)   st_nxt = ARB_CPU;
            end
            ARB_CPU: if (cnt == LAST) st_nxt = ARB_IDLE;
            ARB_REF: if (cnt == LAST) st_nxt = ARB_IDLE;
            ARB_EXT: if (!strobe_act) st_nxt = ARB_IDLE;
            default: st_nxt = ARB_IDLE;
        endcase
    end

    always_comb begin
        gnt_cpu    = 1'b0;
        gnt_ref    = 1'b0;
        gnt_ext    = 1'b0;
        data_valid = 1'b0;
        unique case (st)
            ARB_IDLE: ;
            ARB_CPU:  gnt_cpu = 1'b1;
            ARB_REF:  gnt_ref = 1'b1;
            ARB_EXT: begin
                gnt_ext    = 1'b1;
                data_valid = (cnt == LAST);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/shm_lane_steer.sv
module shm_lane_steer
    import shmem_pkg::*;
#(
    parameter int unsigned LOC_W = 15
) (
    input  logic              active,
    input  logic              word,
    input  logic              odd,
    input  logic [LOC_W-1:0]  loc_addr,
    input  logic [DATA_W-1:0] sys_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [2:0]        lane_en,
    output logic [1:0]        ram_be,
    output logic [LOC_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [DATA_W-1:0] sys_rdata
);

    always_comb begin
        lane_en            = '0;
        lane_en[LP_DIRECT] = active && (word || odd);
        lane_en[LP_SWAP]   = active && !word && !odd;
        lane_en[LP_HIGH]   = active && word;
    end

    always_comb begin
        ram_wdata = '0;
        sys_rdata = '0;
        ram_be    = {lane_en[LP_SWAP] | lane_en[LP_HIGH], lane_en[LP_DIRECT]};
        ram_addr  = active ? loc_addr : '0;
        if (lane_en[LP_DIRECT]) begin
            ram_wdata[LANE_W-1:0] = sys_wdata[LANE_W-1:0];
            sys_rdata[LANE_W-1:0] = ram_rdata[LANE_W-1:0];
        end
        if (lane_en[LP_SWAP]) begin
            ram_wdata[DATA_W-1:LANE_W] = sys_wdata[LANE_W-1:0];
            sys_rdata[LANE_W-1:0]      = ram_rdata[DATA_W-1:LANE_W];
        end
        if (lane_en[LP_HIGH]) begin
            ram_wdata[DATA_W-1:LANE_W] = sys_wdata[DATA_W-1:LANE_W];
            sys_rdata[DATA_W-1:LANE_W] = ram_rdata[DATA_W-1:LANE_W];
        end
    end

endmodule

// File: rtl/shmem_bridge.sv
module shmem_bridge
    import shmem_pkg::*;
#(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned BASE_W  = 4,
    parameter int unsigned CYC_LEN = 3,
    localparam int unsigned LOC_W  = ADDR_W - BASE_W - 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              init_n,
    input  logic [BASE_W-1:0] base_sel,
    input  logic [ADDR_W-1:0] sys_addr,
    input  logic              sys_strobe_n,
    input  logic              sys_word,
    input  logic [15:0]       sys_wdata,
    output logic [15:0]       sys_rdata,
    output logic              sys_xack_n,
    output logic              busrq_n,
    input  logic              busak_n,
    output logic              latch_oe_n,
    input  logic              cpu_req,
    output logic              gnt_cpu,
    input  logic              ref_req,
    output logic              gnt_ref,
    output logic              gnt_ext,
    output logic [2:0]        lane_en,
    output logic [1:0]        ram_be,
    output logic [LOC_W-1:0]  ram_addr,
    output logic [15:0]       ram_wdata,
    input  logic [15:0]       ram_rdata
);

    logic rst_n;
    logic strobe_act;
    logic hit_q;
    logic ext_want;
    logic rq_idle;
    logic cpu_ok;
    logic data_valid;

    assign rst_n  = por_n & init_n;
    assign cpu_ok = cpu_req && rq_idle && busak_n;

    shm_addr_match #(
        .BASE_W      (BASE_W),
        .SYNC_STAGES (2)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_top   (sys_addr[ADDR_W-1 -: BASE_W]),
        .base_sel   (base_sel),
        .strobe_n   (sys_strobe_n),
        .strobe_act (strobe_act),
        .hit_q      (hit_q)
    );

    shm_req_fsm u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_q      (hit_q),
        .strobe_act (strobe_act),
        .busak_n    (busak_n),
        .busrq_n    (busrq_n),
        .ext_want   (ext_want),
        .rq_idle    (rq_idle)
    );

    shm_arb_fsm #(
        .CYC_LEN (CYC_LEN)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_ok     (cpu_ok),
        .ref_req    (ref_req),
        .ext_want   (ext_want),
        .strobe_act (strobe_act),
        .gnt_cpu    (gnt_cpu),
        .gnt_ref    (gnt_ref),
        .gnt_ext    (gnt_ext),
        .data_valid (data_valid)
    );

    shm_lane_steer #(
        .LOC_W (LOC_W)
    ) u_steer (
        .active    (gnt_ext),
        .word      (sys_word),
        .odd       (sys_addr[0]),
        .loc_addr  (sys_addr[LOC_W:1]),
        .sys_wdata (sys_wdata),
        .ram_rdata (ram_rdata),
        .lane_en   (lane_en),
        .ram_be    (ram_be),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .sys_rdata (sys_rdata)
    );

    assign sys_xack_n = ~(gnt_ext && data_valid);
    // CPU address latch floats whenever the CPU has handed over its bus
    assign latch_oe_n = ~busak_n | gnt_ext;

endmodule

// File: rtl/shmem_bridge_chk.sv
module shmem_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busak_n,
    input logic       busrq_n,
    input logic       sys_xack_n,
    input logic       latch_oe_n,
    input logic       gnt_cpu,
    input logic       gnt_ref,
    input logic       gnt_ext,
    input logic [2:0] lane_en
);

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_cpu, gnt_ref, gnt_ext}));

    // R3
    ext_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_ext |-> !busak_n);

    // R4
    latch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busak_n |-> latch_oe_n);

    // R5
    xack_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_xack_n |-> gnt_ext);

    // R11
    lanes_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_en != 3'b000) |-> (gnt_ext && $countones(lane_en) <= 2));

    // R6
    busrq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busrq_n && !sys_xack_n) |=> (busrq_n == sys_xack_n));

endmodule

bind shmem_bridge shmem_bridge_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busak_n    (busak_n),
    .busrq_n    (busrq_n),
    .sys_xack_n (sys_xack_n),
    .latch_oe_n (latch_oe_n),
    .gnt_cpu    (gnt_cpu),
    .gnt_ref    (gnt_ref),
    .gnt_ext    (gnt_ext),
    .lane_en    (lane_en)
);

// File: tb/shmem_bridge_test.sv
`timescale 1ns/1ps
module shmem_bridge_test;

    localparam int ADDR_W  = 20;
    localparam int BASE_W  = 4;
    localparam int CYC_LEN = 3;
    localparam int LOC_W   = ADDR_W - BASE_W - 1;
    localparam logic [BASE_W-1:0] BASE = 4'hC;

    logic clk = 1'b0;
    logic por_n = 1'b0, init_n = 1'b1;
    logic [BASE_W-1:0] base_sel = BASE;
    logic [ADDR_W-1:0] sys_addr = '0;
    logic sys_strobe_n = 1'b1, sys_word = 1'b0;
    logic [15:0] sys_wdata = '0, ram_rdata = '0;
    logic [15:0] sys_rdata, ram_wdata;
    logic sys_xack_n, busrq_n, latch_oe_n, gnt_cpu, gnt_ref, gnt_ext;
    logic busak_n = 1'b1, cpu_req = 1'b0, ref_req = 1'b0;
    logic [2:0] lane_en;
    logic [1:0] ram_be;
    logic [LOC_W-1:0] ram_addr;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    shmem_bridge #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .CYC_LEN(CYC_LEN)) uut (
        .clk(clk), .por_n(por_n), .init_n(init_n), .base_sel(base_sel),
        .sys_addr(sys_addr), .sys_strobe_n(sys_strobe_n), .sys_word(sys_word),
        .sys_wdata(sys_wdata), .sys_rdata(sys_rdata), .sys_xack_n(sys_xack_n),
        .busrq_n(busrq_n), .busak_n(busak_n), .latch_oe_n(latch_oe_n),
        .cpu_req(cpu_req), .gnt_cpu(gnt_cpu), .ref_req(ref_req), .gnt_ref(gnt_ref),
        .gnt_ext(gnt_ext), .lane_en(lane_en), .ram_be(ram_be), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic logic [2:0] exp_lanes(logic word, logic odd);
        if (word) return 3'b101;
        return odd ? 3'b001 : 3'b010;
    endfunction

    function automatic logic [1:0] exp_be(logic word, logic odd);
        if (word) return 2'b11;
        return odd ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [15:0] exp_wr(logic word, logic odd, logic [15:0] d);
        if (word) return d;
        return odd ? {8'h00, d[7:0]} : {d[7:0], 8'h00};
    endfunction

    function automatic logic [15:0] exp_rd(logic word, logic odd, logic [15:0] d);
        if (word) return d;
        return odd ? {8'h00, d[7:0]} : {8'h00, d[15:8]};
    endfunction

    // full external transfer with cycle-exact checks
    task automatic ext_xfer(logic word, logic [ADDR_W-BASE_W-1:0] low,
                            logic [15:0] wd, logic [15:0] rd);
        sys_addr = {BASE, low};
        sys_word = word;
        sys_wdata = wd;
        ram_rdata = rd;
        sys_strobe_n = 1'b0;
        edges(3);
        check("R2 busrq early", busrq_n, 1);
        edges(1);
        check("R2 busrq due", busrq_n, 0);
        check("R4 latch enabled", latch_oe_n, 0);
        busak_n = 1'b0;
        edges(1);
        check("R3 grant early", gnt_ext, 0);
        check("R4 latch off", latch_oe_n, 1);
        edges(1);
        check("R3 grant due", gnt_ext, 1);
        check("R11 lanes", lane_en, exp_lanes(word, low[0]));
        check("R11 be", ram_be, exp_be(word, low[0]));
        check("R11 wdata", ram_wdata, exp_wr(word, low[0], wd));
        check("R11 rdata", sys_rdata, exp_rd(word, low[0], rd));
        check("R11 addr", ram_addr, low[LOC_W:1]);
        edges(CYC_LEN - 2);
        check("R5 xack early", sys_xack_n, 1);
        edges(1);
        check("R5 xack due", sys_xack_n, 0);
        edges(2);
        check("R6 busrq held", busrq_n, 0);
        sys_strobe_n = 1'b1;
        edges(2);
        check("R6 busrq before release", busrq_n, 0);
        check("R5 xack held", sys_xack_n, 0);
        edges(1);
        check("R6 busrq released", busrq_n, 1);
        check("R5 xack released", sys_xack_n, 1);
        check("R11 lanes off", lane_en, 0);
        cpu_req = 1'b1;
        busak_n = 1'b1;
        edges(1);
        check("R7 cpu early", gnt_cpu, 0);
        edges(1);
        check("R7 cpu due", gnt_cpu, 1);
        cpu_req = 1'b0;
        edges(CYC_LEN + 1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        edges(2);
        // R12 reset state
        check("R12 busrq", busrq_n, 1);
        check("R12 grants", {gnt_cpu, gnt_ref, gnt_ext}, 0);
        check("R12 lanes", lane_en, 0);
        check("R12 xack", sys_xack_n, 1);
        por_n = 1'b1;
        edges(2);

        // R1 mismatched base
        sys_addr = {4'h3, 16'h0100};
        sys_strobe_n = 1'b0;
        edges(8);
        check("R1 no request on mismatch", busrq_n, 1);
        sys_strobe_n = 1'b1;
        edges(4);

        // directed transfers: odd byte, even byte, word
        ext_xfer(1'b0, 16'h0041, 16'hA55A, 16'h1234);
        ext_xfer(1'b0, 16'h0040, 16'hA55A, 16'h1234);
        ext_xfer(1'b1, 16'h0FF0, 16'hBEEF, 16'hCAFE);

        // R8 refresh over cpu, R10 length, R9 no back-to-back refresh
        ref_req = 1'b1;
        cpu_req = 1'b1;
        edges(1);
        check("R8 refresh first", {gnt_ref, gnt_cpu}, 2'b10);
        edges(CYC_LEN - 1);
        check("R10 refresh length", gnt_ref, 1);
        edges(1);
        check("R10 refresh ends", gnt_ref, 0);
        edges(1);
        check("R9 cpu after refresh", {gnt_ref, gnt_cpu}, 2'b01);
        edges(CYC_LEN - 1);
        check("R10 cpu length", gnt_cpu, 1);
        edges(2);
        check("R9 refresh again", gnt_ref, 1);
        ref_req = 1'b0;
        cpu_req = 1'b0;
        edges(CYC_LEN + 2);

        // R8 refresh over external, R9 external beats held refresh
        sys_addr = {BASE, 16'h0201};
        sys_word = 1'b0;
        sys_strobe_n = 1'b0;
        edges(4);
        check("R2 busrq", busrq_n, 0);
        busak_n = 1'b0;
        ref_req = 1'b1;
        edges(1);
        check("R8 refresh before ext", {gnt_ref, gnt_ext}, 2'b10);
        edges(CYC_LEN + 1);
        check("R9 ext after refresh", {gnt_ref, gnt_ext}, 2'b01);
        sys_strobe_n = 1'b1;
        ref_req = 1'b0;
        edges(3);
        check("R6 release", busrq_n, 1);
        busak_n = 1'b1;
        edges(CYC_LEN + 3);

        // R12 external init in mid transfer
        sys_addr = {BASE, 16'h0010};
        sys_strobe_n = 1'b0;
        edges(4);
        busak_n = 1'b0;
        edges(2);
        check("R3 grant before init", gnt_ext, 1);
        init_n = 1'b0;
        #1;
        check("R12 init clears grant", {gnt_ext, lane_en}, 0);
        check("R12 init clears busrq", busrq_n, 1);
        sys_strobe_n = 1'b1;
        busak_n = 1'b1;
        edges(2);
        init_n = 1'b1;
        edges(3);

        // random transfers
        for (int i = 0; i < 16; i++) begin
            logic w;
            logic [15:0] lo;
            w = 1'($urandom % 2);
            lo = 16'($urandom);
            ext_xfer(w, lo, 16'($urandom), 16'($urandom));
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule